// File: doc/BRIEF.md
# Windowed Register File

This block is a processor register file built as a ring of overlapping register windows, with a separate bank of global registers. Each window has three groups. The incoming group holds parameters and results. The local group is private to the window. The outgoing group passes arguments to the next procedure. The outgoing group of window J is the same storage as the incoming group of window J+1, so a caller hands arguments to its callee without copying any data.

The block has two combinational read ports and one write port. All three take a 5-bit architectural register number. The number is translated to a physical index using the current window pointer. A call pulse moves that pointer forward by one window and a return pulse moves it back by one, both wrapping around the ring. A saved window pointer marks the most recently spilled window. A call that would land on that window is held and raises a spill request. A return that would land on it is held and raises a fill request.

While a request is pending, the windowed register numbers address the window being transferred. An external agent can therefore copy that window out or back in through the normal ports. It then pulses done. The saved window pointer then moves by one and the held call or return completes. Copying the data to and from memory is left to the agent.

Top module: `windowed_regfile`

## Requirements
- R1: Register numbers 0 to 7 select eight global registers that are the same storage whatever the window pointer is.
- R2: Register numbers 8–11 select the incoming group, 12–15 the local group and 16–19 the outgoing group of the addressed window. Outgoing register 16+k of window J is incoming register 8+k of window (J+1) mod 6, and this includes the wrap from window 5 to window 0.
- R3: Local registers 12–15 are private: each window has its own copy.
- R4: Reads are combinational. A write and a read of the same register in the same cycle return the new write data on the read port.
- R5: Register numbers 20–31 read as zero, and writes to them change no register.
- R6: After reset the current pointer is 0, the saved pointer is 5, neither request is raised and every register reads zero.
- R7: With no request pending, a call alone moves the current pointer to (cwp+1) mod 6 and a return alone moves it to (cwp−1) mod 6, provided the target window is not the saved window.
- R8: A call whose target equals the saved pointer leaves the current pointer unchanged and raises spill_req_o from the next cycle, with xfer_win_o = (swp+1) mod 6. On done the saved pointer steps to (swp+1) mod 6, the call completes and the request drops.
- R9: A return whose target equals the saved pointer leaves the current pointer unchanged and raises fill_req_o from the next cycle, with xfer_win_o = swp. On done the saved pointer steps to (swp−1) mod 6, the return completes and the request drops.
- R10: While a request is pending, call and return are ignored, and register numbers 8–19 are offset by xfer_win_o instead of the current pointer.
- R11: A call and a return in the same cycle are ignored.
- R12: The current and saved pointers are never equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call pulse |
| ret_i | input | 1 | Return pulse |
| ra_addr_i | input | 5 | Read port A register number |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 5 | Read port B register number |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 5 | Write register number |
| wd_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |
| spill_req_o | output | 1 | Overflow trap: a window must be saved |
| fill_req_o | output | 1 | Underflow trap: a window must be restored |
| xfer_win_o | output | 3 | Window to be saved or restored |
| xfer_done_i | input | 1 | Pulse from the agent: the transfer is finished |

## Verification
The translation is tested by writing distinct values into the global, incoming, local and outgoing groups at one window. The bench then reads them back after a call and after a return. This separates true overlap from private storage, and separates window-independent globals from windowed registers.

The pointer logic is driven through a full ring of calls until the spill trap fires, and then through a full ring of returns until the fill trap fires. This exercises the wrap-around of both pointers. It also shows that the port offset follows the transfer window while a request is pending.

Same-cycle write and read, writes to out-of-range numbers, and simultaneous call and return are each tried on their own. This keeps forwarding, write suppression and pulse rejection apart from one another.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_SPILL = 2'd1,
    TS_FILL  = 2'd2
  } trap_st_e;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
  parameter int NWIN = 6,
  parameter int NGLB = 8,
  parameter int NPAR = 4,
  parameter int NLOC = 4,
  parameter int AW   = 5,
  parameter int WW   = 3,
  parameter int PW   = 6
) (
  input  logic [AW-1:0] arch_i,
  input  logic [WW-1:0] win_i,
  output logic [PW-1:0] phys_o,
  output logic          hit_o
);
  localparam int WSZ  = NPAR + NLOC;
  localparam int T_LO = NGLB + NPAR + NLOC;
  localparam int T_HI = T_LO + NPAR;

  int a, w, nw, pi;

  always_comb begin
    a  = int'(arch_i);
    w  = int'(win_i);
    nw = (w == NWIN - 1) ? 0 : w + 1;
    hit_o = 1'b1;
    if (a < NGLB)      pi = a;
    else if (a < T_LO) pi = NGLB + w * WSZ + (a - NGLB);
    else if (a < T_HI) pi = NGLB + nw * WSZ + (a - T_LO); // outgoing = next window's incoming
    else begin
      pi    = 0;
      hit_o = 1'b0;
    end
    phys_o = PW'(pi);
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 56,
  parameter int PW    = 6,
  parameter int NRD   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PW-1:0]            wa_i,
  input  logic [DW-1:0]            wd_i,
  input  logic [NRD-1:0][PW-1:0]   ra_i,
  input  logic [NRD-1:0]           rhit_i,
  output logic [NRD-1:0][DW-1:0]   rd_o
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (we_i && (int'(wa_i) < NPHYS)) begin
      mem[wa_i] <= wd_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if (!rhit_i[g] || int'(ra_i[g]) >= NPHYS) rd_o[g] = '0;
      else if (we_i && wa_i == ra_i[g])         rd_o[g] = wd_i;
      else                                      rd_o[g] = mem[ra_i[g]];
    end
  end
endmodule

// File: rtl/wrf_wptr_ctrl.sv
module wrf_wptr_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int WW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          done_i,
  output logic [WW-1:0] cwp_o,
  output logic [WW-1:0] swp_o,
  output logic          spill_o,
  output logic          fill_o,
  output logic [WW-1:0] xwin_o
);
  trap_st_e      st_q;
  logic [WW-1:0] cwp_q, swp_q;

  function automatic logic [WW-1:0] step_up(input logic [WW-1:0] v);
    return (v == WW'(NWIN - 1)) ? '0 : v + WW'(1);
  endfunction

  function automatic logic [WW-1:0] step_dn(input logic [WW-1:0] v);
    return (v == '0) ? WW'(NWIN - 1) : v - WW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TS_IDLE;
      cwp_q <= '0;
      swp_q <= WW'(NWIN - 1);
    end else begin
      unique case (st_q)
        TS_IDLE: begin
          if (call_i && !ret_i) begin
            if (step_up(cwp_q) == swp_q) st_q  <= TS_SPILL;
            else                         cwp_q <= step_up(cwp_q);
          end else if (ret_i && !call_i) begin
            if (step_dn(cwp_q) == swp_q) st_q  <= TS_FILL;
            else                         cwp_q <= step_dn(cwp_q);
          end
        end
        TS_SPILL: if (done_i) begin
          swp_q <= step_up(swp_q);
          cwp_q <= step_up(cwp_q);
          st_q  <= TS_IDLE;
        end
        TS_FILL: if (done_i) begin
          swp_q <= step_dn(swp_q);
          cwp_q <= step_dn(cwp_q);
          st_q  <= TS_IDLE;
        end
        default: st_q <= TS_IDLE;
      endcase
    end
  end

  assign cwp_o   = cwp_q;
  assign swp_o   = swp_q;
  assign spill_o = (st_q == TS_SPILL);
  assign fill_o  = (st_q == TS_FILL);
  assign xwin_o  = (st_q == TS_SPILL) ? step_up(swp_q) : swp_q;
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int NWIN = 6,
  parameter int NGLB = 8,
  parameter int NPAR = 4,
  parameter int NLOC = 4,
  parameter int DW   = 32,
  parameter int AW   = 5,
  parameter int WW   = $clog2(NWIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_addr_i,
  input  logic [DW-1:0] wd_i,
  output logic [WW-1:0] cwp_o,
  output logic [WW-1:0] swp_o,
  output logic          spill_req_o,
  output logic          fill_req_o,
  output logic [WW-1:0] xfer_win_o,
  input  logic          xfer_done_i
);
  localparam int NPHYS = NGLB + NWIN * (NPAR + NLOC);
  localparam int PW    = $clog2(NPHYS);
  localparam int NPRT  = 3; // two reads, one write

  logic [WW-1:0]               win_sel;
  logic [NPRT-1:0][AW-1:0]     arch;
  logic [NPRT-1:0][PW-1:0]     phys;
  logic [NPRT-1:0]             hit;
  logic [1:0][DW-1:0]          rdata;

  wrf_wptr_ctrl #(.NWIN(NWIN), .WW(WW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .done_i  (xfer_done_i),
    .cwp_o   (cwp_o),
    .swp_o   (swp_o),
    .spill_o (spill_req_o),
    .fill_o  (fill_req_o),
    .xwin_o  (xfer_win_o)
  );

  // pending transfer retargets the windowed numbers
  assign win_sel = (spill_req_o || fill_req_o) ? xfer_win_o : cwp_o;
  assign arch    = {wa_addr_i, rb_addr_i, ra_addr_i};

  for (genvar g = 0; g < NPRT; g++) begin : g_map
    wrf_addr_map #(
      .NWIN(NWIN), .NGLB(NGLB), .NPAR(NPAR), .NLOC(NLOC),
      .AW(AW), .WW(WW), .PW(PW)
    ) u_map (
      .arch_i (arch[g]),
      .win_i  (win_sel),
      .phys_o (phys[g]),
      .hit_o  (hit[g])
    );
  end

  wrf_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(2)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i && hit[2]),
    .wa_i   (phys[2]),
    .wd_i   (wd_i),
    .ra_i   (phys[1:0]),
    .rhit_i (hit[1:0]),
    .rd_o   (rdata)
  );

  assign ra_data_o = rdata[0];
  assign rb_data_o = rdata[1];
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int NWIN  = 6,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int WW    = 3,
  parameter int NARCH = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          call_i,
  input logic          ret_i,
  input logic [AW-1:0] ra_addr_i,
  input logic [DW-1:0] ra_data_o,
  input logic          we_i,
  input logic [AW-1:0] wa_addr_i,
  input logic [DW-1:0] wd_i,
  input logic [WW-1:0] cwp_o,
  input logic [WW-1:0] swp_o,
  input logic          spill_req_o,
  input logic          fill_req_o,
  input logic          xfer_done_i
);
  logic [WW-1:0] nxt, prv;
  logic          idle;
  assign nxt  = (cwp_o == WW'(NWIN - 1)) ? '0 : cwp_o + WW'(1);
  assign prv  = (cwp_o == '0) ? WW'(NWIN - 1) : cwp_o - WW'(1);
  assign idle = !spill_req_o && !fill_req_o;

  // R12
  ptr_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_o != swp_o);

  // R8
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spill_req_o && fill_req_o));

  // R7
  call_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && call_i && !ret_i && nxt != swp_o |=> cwp_o == $past(nxt));

  // R7
  ret_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && ret_i && !call_i && prv != swp_o |=> cwp_o == $past(prv));

  // R8
  spill_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && call_i && !ret_i && nxt == swp_o |=> spill_req_o && $stable(cwp_o));

  // R9
  fill_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && ret_i && !call_i && prv == swp_o |=> fill_req_o && $stable(cwp_o));

  // R8
  spill_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_req_o && xfer_done_i |=> !spill_req_o && cwp_o == $past(swp_o));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle && !xfer_done_i |=> $stable(cwp_o) && $stable(swp_o));

  // R11
  both_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && call_i && ret_i |=> $stable(cwp_o) && idle);

  // R4
  fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && ra_addr_i == wa_addr_i && int'(wa_addr_i) < NARCH |-> ra_data_o == wd_i);
endmodule

bind windowed_regfile wrf_chk #(
  .NWIN(NWIN), .DW(DW), .AW(AW), .WW(WW), .NARCH(NGLB + 2 * NPAR + NLOC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .ra_addr_i   (ra_addr_i),
  .ra_data_o   (ra_data_o),
  .we_i        (we_i),
  .wa_addr_i   (wa_addr_i),
  .wd_i        (wd_i),
  .cwp_o       (cwp_o),
  .swp_o       (swp_o),
  .spill_req_o (spill_req_o),
  .fill_req_o  (fill_req_o),
  .xfer_done_i (xfer_done_i)
);

// File: tb/tb_windowed_regfile.sv
module tb_windowed_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, we_i = 1'b0, xfer_done_i = 1'b0;
  logic [4:0]  ra_addr_i = '0, rb_addr_i = '0, wa_addr_i = '0;
  logic [31:0] wd_i = '0, ra_data_o, rb_data_o;
  logic [2:0]  cwp_o, swp_o, xfer_win_o;
  logic        spill_req_o, fill_req_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  windowed_regfile dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we_i = 1'b1; wa_addr_i = a; wd_i = d;
    cyc();
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    ra_addr_i = a;
    #1 v = ra_data_o;
  endtask

  task automatic pulse(input bit c, input bit r, input bit d);
    call_i = c; ret_i = r; xfer_done_i = d;
    cyc();
    call_i = 1'b0; ret_i = 1'b0; xfer_done_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R6 cwp", 32'(cwp_o), 0);
    chk("R6 swp", 32'(swp_o), 5);
    chk("R6 req", {30'd0, spill_req_o, fill_req_o}, 0);
    rd(5'd3, v);  chk("R6 global", v, 0);
    rd(5'd14, v); chk("R6 local", v, 0);
  endtask

  task automatic t_groups();
    logic [31:0] v;
    wr(5'd5, 32'hA5);
    wr(5'd16, 32'h1111);
    wr(5'd12, 32'h2222);
    wr(5'd8, 32'h3333);
    pulse(1, 0, 0);
    chk("R7 call", 32'(cwp_o), 1);
    rd(5'd5, v);  chk("R1 global seen in w1", v, 32'hA5);
    rd(5'd8, v);  chk("R2 overlap out->in", v, 32'h1111);
    rd(5'd12, v); chk("R3 local private", v, 0);
    wr(5'd12, 32'h4444);
    pulse(0, 1, 0);
    chk("R7 return", 32'(cwp_o), 0);
    rd(5'd12, v); chk("R3 local kept", v, 32'h2222);
    rd(5'd16, v); chk("R2 outgoing kept", v, 32'h1111);
    rd(5'd8, v);  chk("R2 incoming", v, 32'h3333);
  endtask

  task automatic t_forward();
    logic [31:0] v;
    ra_addr_i = 5'd13; rb_addr_i = 5'd15;
    we_i = 1'b1; wa_addr_i = 5'd13; wd_i = 32'h77;
    #1;
    chk("R4 forward", ra_data_o, 32'h77);
    chk("R4 other port", rb_data_o, 0);
    cyc();
    we_i = 1'b0;
    rd(5'd13, v); chk("R4 stored", v, 32'h77);
  endtask

  task automatic t_invalid();
    logic [31:0] snap [20];
    logic [31:0] v;
    for (int i = 0; i < 20; i++) begin
      rb_addr_i = 5'(i); #1 snap[i] = rb_data_o;
    end
    wr(5'd20, 32'hDEAD);
    wr(5'd31, 32'hBEEF);
    rd(5'd20, v); chk("R5 read zero", v, 0);
    rd(5'd31, v); chk("R5 read zero", v, 0);
    for (int i = 0; i < 20; i++) begin
      rb_addr_i = 5'(i); #1 chk("R5 no alias", rb_data_o, snap[i]);
    end
  endtask

  task automatic t_both();
    pulse(1, 1, 0);
    chk("R11 cwp", 32'(cwp_o), 0);
    chk("R11 req", {30'd0, spill_req_o, fill_req_o}, 0);
  endtask

  task automatic t_spill();
    logic [31:0] v;
    for (int k = 1; k <= 4; k++) begin
      pulse(1, 0, 0);
      chk("R7 step", 32'(cwp_o), 32'(k));
    end
    pulse(1, 0, 0);
    chk("R8 spill_req", 32'(spill_req_o), 1);
    chk("R8 cwp held", 32'(cwp_o), 4);
    chk("R8 xfer_win", 32'(xfer_win_o), 0);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    chk("R10 cwp ignored", 32'(cwp_o), 4);
    chk("R10 swp ignored", 32'(swp_o), 5);
    rd(5'd8, v);  chk("R10 xfer in", v, 32'h3333);
    rd(5'd12, v); chk("R10 xfer local", v, 32'h2222);
    pulse(0, 0, 1);
    chk("R8 done swp", 32'(swp_o), 0);
    chk("R8 done cwp", 32'(cwp_o), 5);
    chk("R8 req drop", 32'(spill_req_o), 0);
    rd(5'd16, v); chk("R2 wrap 5->0", v, 32'h3333);
  endtask

  task automatic t_fill();
    logic [31:0] v;
    for (int k = 4; k >= 1; k--) begin
      pulse(0, 1, 0);
      chk("R7 back", 32'(cwp_o), 32'(k));
    end
    pulse(0, 1, 0);
    chk("R9 fill_req", 32'(fill_req_o), 1);
    chk("R9 cwp held", 32'(cwp_o), 1);
    chk("R9 xfer_win", 32'(xfer_win_o), 0);
    wr(5'd12, 32'h5555);
    pulse(0, 0, 1);
    chk("R9 done swp", 32'(swp_o), 5);
    chk("R9 done cwp", 32'(cwp_o), 0);
    chk("R9 req drop", 32'(fill_req_o), 0);
    rd(5'd12, v); chk("R10 fill write", v, 32'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_groups();
    t_forward();
    t_invalid();
    t_both();
    t_spill();
    t_fill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule